// File: doc/BRIEF.md
# Serial Receive Queue with Fill Trigger and Idle Timeout

This block buffers received bytes for an asynchronous serial controller. A deserializer hands each byte over with a one-cycle valid pulse; the CPU side takes bytes out with a read strobe and sees the oldest byte combinationally on the read-data port while the strobe is high. The queue is sixteen bytes deep and is kept with a write pointer, a read pointer and an occupancy count.

A two-bit trigger code, written through a control strobe, sets how full the queue must get before the data-ready flag rises. A queue that holds fewer bytes than that and then goes quiet is also flagged: each accepted byte that leaves the queue under the trigger restarts a fifteen-bit-time idle timer, counted on an external bit-time tick, and the flag rises when the timer expires. The flag drives a level interrupt request, gated by an enable input.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the count is 0, the data-ready flag and interrupt are low, the trigger code is 0, and read data shows 0xFF.
- R2: Bytes are returned in arrival order. Each read of a non-empty queue presents the oldest byte on `rd_data` during the strobe cycle, lowers the count by one, and the pointers wrap after entry 15.
- R3: A byte offered while the queue holds 16 bytes is dropped, and the stored contents are unchanged.
- R4: While `rx_en` is low, offered bytes are dropped.
- R5: A control write loads `ctl_wdata[7:6]` as the trigger code: 0 selects a threshold of 1 byte, 1 selects 4, 2 selects 8, 3 selects 14. The new threshold applies from the next cycle.
- R6: A control write with `ctl_wdata[1]` set empties the queue, clears the flag and stops the idle timer; a byte offered or a read made in the same cycle is ignored.
- R7: When an accepted byte brings the count to the threshold or above, the flag is set.
- R8: When a read brings the count below the threshold (and no expiry or trigger-reaching push sets it that cycle), the flag is cleared.
- R9: An accepted byte that leaves the count below the threshold restarts the idle timer at 15 ticks; on the 15th `bit_tick` without a further accepted byte the flag is set. An accepted byte that reaches the threshold stops the timer.
- R10: `rx_irq` is high exactly when the flag is set and `rx_irq_en` is high.
- R11: A read of an empty queue shows 0xFF and changes no state.
- R12: An accepted byte and a read in the same cycle leave the count unchanged and keep arrival order.
- R13: `rx_count` always shows the current number of stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Byte offered by the deserializer this cycle |
| rx_data | input | 8 | Offered byte |
| rx_en | input | 1 | Receiver enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control data: [7:6] trigger code, [1] flush |
| rd_strobe | input | 1 | Data read strobe |
| rd_data | output | 8 | Oldest byte, or 0xFF when empty |
| rx_count | output | 5 | Current occupancy |
| bit_tick | input | 1 | One pulse per bit time |
| data_full | output | 1 | Data-ready flag |
| rx_irq | output | 1 | Level receive interrupt request |

## Verification
The bench aims at the pointer wrap with a full queue, where an off-by-one pointer returns bytes out of order, and at a byte offered into a full queue, which a missing full check would write over the oldest entry. It times the idle window exactly: a timer loaded with the wrong value, or not restarted by a later byte, flags one or more ticks early or late, and a timer not stopped at the trigger would raise the flag again after a read had cleared it. Flushes that coincide with a push, empty reads and pushes paired with reads probe the priority order; a wrong order shows up as a nonzero count or a lost byte.

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DEPTH        = 16,
  parameter int DW           = 8,
  parameter int TIMEOUT_BITS = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_valid,
  input  logic [DW-1:0]            rx_data,
  input  logic                     rx_en,
  input  logic                     rx_irq_en,
  input  logic                     ctl_wr,
  input  logic [7:0]               ctl_wdata,
  input  logic                     rd_strobe,
  output logic [DW-1:0]            rd_data,
  output logic [$clog2(DEPTH):0]   rx_count,
  input  logic                     bit_tick,
  output logic                     data_full,
  output logic                     rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = $clog2(TIMEOUT_BITS + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic [CW-1:0] count, cnt_nxt, thr;
  logic [1:0]    trig_code;
  logic          t_on;
  logic [TW-1:0] t_cnt;
  logic          flush, do_push, do_pop, expire;

  assign flush   = ctl_wr & ctl_wdata[1];
  assign do_push = rx_valid & rx_en & (count != CW'(DEPTH)) & ~flush;
  assign do_pop  = rd_strobe & (count != '0) & ~flush;
  assign expire  = t_on & bit_tick & (t_cnt == TW'(1));
  assign cnt_nxt = count + CW'(do_push) - CW'(do_pop);

  always_comb begin
    case (trig_code)
      2'd0:    thr = CW'(1);
      2'd1:    thr = CW'(4);
      2'd2:    thr = CW'(8);
      default: thr = CW'(14);
    endcase
  end

  assign rd_data  = (count == '0) ? '1 : mem[tail];
  assign rx_count = count;
  assign rx_irq   = data_full & rx_irq_en;

  always_ff @(posedge clk) begin
    if (do_push) mem[head] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      trig_code <= '0;
      data_full <= 1'b0;
      t_on      <= 1'b0;
      t_cnt     <= '0;
    end else begin
      if (ctl_wr) trig_code <= ctl_wdata[7:6];
      if (flush) begin
        head      <= '0;
        tail      <= '0;
        count     <= '0;
        data_full <= 1'b0;
        t_on      <= 1'b0;
      end else begin
        if (do_push) head <= head + AW'(1);
        if (do_pop)  tail <= tail + AW'(1);
        count <= cnt_nxt;
        if (expire || (do_push && cnt_nxt >= thr))
          data_full <= 1'b1;
        else if (do_pop && cnt_nxt < thr)
          data_full <= 1'b0;
        if (do_push) begin
          t_on  <= (cnt_nxt < thr);
          t_cnt <= TW'(TIMEOUT_BITS);
        end else if (expire) begin
          t_on <= 1'b0;
        end else if (t_on && bit_tick) begin
          t_cnt <= t_cnt - TW'(1);
        end
      end
    end
  end

  p_count_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !rd_strobe && !flush) |=> (count == CW'(DEPTH) && $stable(tail)));

  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !data_full));

  p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_strobe && !flush) |=> $stable(count));

  p_trig_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && cnt_nxt >= thr) |=> data_full);

  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && count == '0 && !rx_valid && !ctl_wr) |=> (count == '0 && $stable(tail) && $stable(head)));
endmodule

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, rx_valid, rx_en, rie, ctl_wr, rd_strobe, bit_tick;
  logic [7:0] rx_data, ctl_wdata;
  wire  [7:0] rd_data;
  wire  [4:0] rx_count;
  wire        data_full, rx_irq;

  serial_rx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_en(rx_en), .rx_irq_en(rie), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_count(rx_count),
    .bit_tick(bit_tick), .data_full(data_full), .rx_irq(rx_irq)
  );

  int total = 0, bad = 0;
  bit done = 0;
  byte unsigned q[$];
  int  thr = 1;
  bit  mflag = 0, tact = 0;
  int  tcnt = 0;

  function automatic int code2thr(input logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [7:0] d, input logic rd,
                      input logic cw, input logic [7:0] cwd, input logic tk);
    bit pu, po, ex;
    int n, nthr;
    rx_valid = v; rx_data = d; rd_strobe = rd; ctl_wr = cw; ctl_wdata = cwd; bit_tick = tk;
    #1;
    if (rd) check(tag, "rd_data", int'(rd_data), q.size() > 0 ? int'(q[0]) : 255);
    @(posedge clk);
    nthr = cw ? code2thr(cwd[7:6]) : thr;
    if (cw && cwd[1]) begin
      q.delete(); mflag = 0; tact = 0;
    end else begin
      po = rd && q.size() > 0;
      pu = v && rx_en && q.size() < 16;
      ex = tact && tk && tcnt == 1;
      if (po) void'(q.pop_front());
      if (pu) q.push_back(d);
      n = q.size();
      if ((pu && n >= thr) || ex) mflag = 1;
      else if (po && n < thr) mflag = 0;
      if (pu) begin tact = (n < thr); tcnt = 15; end
      else if (ex) tact = 0;
      else if (tact && tk) tcnt--;
    end
    thr = nthr;
    @(negedge clk);
    rx_valid = 0; rd_strobe = 0; ctl_wr = 0; bit_tick = 0;
    check(tag, "rx_count", int'(rx_count), q.size());
    check(tag, "data_full", int'(data_full), int'(mflag));
    check(tag, "rx_irq", int'(rx_irq), int'(mflag & rie));
  endtask

  task automatic push(input string tag, input logic [7:0] d); step(tag, 1, d, 0, 0, 8'h00, 0); endtask
  task automatic pop(input string tag);  step(tag, 0, 8'h00, 1, 0, 8'h00, 0); endtask
  task automatic wctl(input string tag, input logic [7:0] w); step(tag, 0, 8'h00, 0, 1, w, 0); endtask
  task automatic ticks(input string tag, input int k);
    for (int i = 0; i < k; i++) step(tag, 0, 8'h00, 0, 0, 8'h00, 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_data = 0; rx_en = 0; rie = 0;
    ctl_wr = 0; ctl_wdata = 0; rd_strobe = 0; bit_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "rx_count", int'(rx_count), 0);
    check("R1", "data_full", int'(data_full), 0);
    check("R1", "rx_irq", int'(rx_irq), 0);
    check("R1", "rd_data", int'(rd_data), 255);

    // R4: receiver disabled drops bytes
    for (int i = 0; i < 3; i++) push("R4", 8'hA0 + 8'(i));

    rx_en = 1; rie = 1;
    // R7 and R10 with threshold 1
    push("R7", 8'h11);
    rie = 0; ticks("R10", 1);
    rie = 1; ticks("R10", 1);
    // R2 ordering
    for (int i = 0; i < 5; i++) push("R2", 8'h20 + 8'(i));
    for (int i = 0; i < 6; i++) pop("R8");
    // R11 empty reads
    pop("R11"); pop("R11");

    // R5 trigger codes
    wctl("R5", 8'h40);
    for (int i = 0; i < 4; i++) push("R5", 8'h30 + 8'(i));
    pop("R8");
    wctl("R5", 8'h80);
    for (int i = 0; i < 5; i++) push("R5", 8'h40 + 8'(i));
    wctl("R6", 8'h02);
    wctl("R5", 8'hC0);
    for (int i = 0; i < 14; i++) push("R5", 8'h50 + 8'(i));
    pop("R8");
    wctl("R6", 8'h02);

    // R3 full queue with wrap
    wctl("R5", 8'h00);
    for (int i = 0; i < 16; i++) push("R3", 8'h60 + 8'(i));
    for (int i = 0; i < 3; i++) push("R3", 8'hEE);
    for (int i = 0; i < 16; i++) pop("R2");

    // R6 flush beats same-cycle push
    for (int i = 0; i < 5; i++) push("R6", 8'h70 + 8'(i));
    step("R6", 1, 8'h99, 1, 1, 8'h02, 0);
    pop("R11");

    // R9 idle timeout
    wctl("R9", 8'h40);
    push("R9", 8'h81);
    ticks("R9", 14);
    ticks("R9", 1);
    rie = 0; ticks("R10", 2); rie = 1;
    wctl("R6", 8'h42);
    push("R9", 8'h82);
    ticks("R9", 10);
    push("R9", 8'h83);
    ticks("R9", 14);
    ticks("R9", 1);
    wctl("R6", 8'h42);
    for (int i = 0; i < 3; i++) push("R9", 8'h90 + 8'(i));
    ticks("R9", 5);
    push("R9", 8'h93);
    pop("R8");
    ticks("R9", 20);

    // R12 simultaneous push and pop
    wctl("R6", 8'h02);
    push("R12", 8'hB0); push("R12", 8'hB1);
    step("R12", 1, 8'hB2, 1, 0, 8'h00, 0);
    step("R12", 1, 8'hB3, 1, 0, 8'h00, 0);
    for (int i = 0; i < 3; i++) pop("R13");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule